// File: doc/BRIEF.md
# Queue Interrupt Coalescing Controller

This block gathers event pulses from a DMA network engine into a 32-bit raw status register. Each pulse sets its status bit, and the bit stays set until software writes a one to it. A separate enable register decides which raw bits reach the single level interrupt output. Software can read a masked view of the status, which is raw AND enable.

Two queue sources do not set their bits straight from a pulse. These are descriptors arriving on the receive-complete queue and descriptors arriving on the transmit-reclaim queue. For each of these queues the block counts arrivals. It raises the count event when the accumulated number reaches a programmable threshold. If fewer descriptors than the threshold are waiting, an idle timer raises a separate timeout event after a programmable number of cycles and drops the pending count. This limits how often an interrupt fires during bursts and still bounds the delay for a lone packet.

Top module: `irq_coalesce`

## Requirements
- R1: After reset the status is 0, the enable is 0, the irq output is 0 and the masked view is 0. The threshold word (address 3) reads 0x00010001. The receive timeout (address 4) reads 0x10000 and the transmit timeout (address 5) reads 0x50000.
- R2: A pulse on evt_i[n] sets raw bit n at the next clock edge. This covers the per-ring empty, full, almost-empty and almost-full bits in 15:0. The bit then stays set until it is cleared.
- R3: A write to address 0 clears each raw bit whose data bit is 1 and leaves the others unchanged. Writing all ones clears every pending bit.
- R4: If a bit's event arrives in the same cycle as a write-one-to-clear of that bit, the bit stays set.
- R5: Address 2 reads raw AND enable. The enable register is at address 1 and the raw status is at address 0.
- R6: irq_o is registered. It equals the OR of (raw AND enable) as it stood one cycle earlier.
- R7: evt_i bits 17, 19, 28 and 29 are ignored, because only the coalescing logic drives those raw bits.
- R8: Receive arrivals (rx_arrive_i) set raw bit 17 on the arrival that brings the accumulated count to the receive threshold. The receive threshold is bits 15:0 of address 3. The count then restarts from zero.
- R9: Transmit arrivals (tx_arrive_i) set raw bit 19 in the same way. The transmit threshold is bits 31:16 of address 3.
- R10: Suppose at least one receive arrival is pending below the threshold. Then bit 28 is set T cycles after the edge that registered the first pending arrival, where T is the receive timeout. The pending count is dropped at the same time.
- R11: The transmit timeout works in the same way on bit 29, with its value at address 5.
- R12: While no arrivals are pending, the idle timers do not run and no timeout bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Event pulses, one per raw status bit |
| rx_arrive_i | input | 1 | One pulse per descriptor entering the receive-complete queue |
| tx_arrive_i | input | 1 | One pulse per descriptor entering the transmit-reclaim queue |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Level interrupt |

## Verification
The raw, masked and register read values are combinational from state. They become valid one edge after the event or write that changes them, so the bench samples them at the falling edge that follows that edge. The irq output trails the status by a further cycle. The bench therefore models it from the previous cycle's raw and enable, and in the timeout test it checks that irq is low at the falling edge where the status bit first appears and high one cycle later. Timeout results are due exactly T edges after the arrival edge, and the bench checks for the bit being absent at edge T-1 and present at edge T.

// File: rtl/irq_coalesce.sv
module irq_coalesce #(
  parameter int CNT_W = 16,
  parameter int TMO_W = 20,
  parameter int RX_THR_RST = 1,
  parameter int TX_THR_RST = 1,
  parameter int RX_TMO_RST = 'h10000,
  parameter int TX_TMO_RST = 'h50000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] evt_i,
  input  logic        rx_arrive_i,
  input  logic        tx_arrive_i,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);
  localparam int RX_IN = 17;
  localparam int TX_IN = 19;
  localparam int RX_TO = 28;
  localparam int TX_TO = 29;
  localparam logic [31:0] OWN_MASK = (32'd1 << RX_IN) | (32'd1 << TX_IN) |
                                     (32'd1 << RX_TO) | (32'd1 << TX_TO);

  logic [31:0]      raw_q, en_q, set_vec, clr_vec;
  logic [CNT_W-1:0] thr_q [2];
  logic [TMO_W-1:0] tmo_q [2];
  logic [1:0]       arrive, hit_cnt, hit_tmo;
  logic             irq_q;

  assign arrive = {tx_arrive_i, rx_arrive_i};

  for (genvar q = 0; q < 2; q++) begin : g_q
    logic [CNT_W-1:0] cnt;
    logic [TMO_W-1:0] tmr;
    logic [CNT_W:0]   cnt_nx;
    logic [TMO_W:0]   tmr_nx;
    localparam int TO_BIT = (q == 0) ? RX_TO : TX_TO;

    assign cnt_nx = {1'b0, cnt} + (CNT_W+1)'(1);
    assign tmr_nx = {1'b0, tmr} + (TMO_W+1)'(1);
    assign hit_cnt[q] = arrive[q] && (cnt_nx >= {1'b0, thr_q[q]});
    assign hit_tmo[q] = !hit_cnt[q] && (cnt != '0) && (tmr_nx >= {1'b0, tmo_q[q]});

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        tmr <= '0;
      end else if (hit_cnt[q]) begin
        cnt <= '0;
        tmr <= '0;
      end else if (hit_tmo[q]) begin
        cnt <= arrive[q] ? CNT_W'(1) : '0;
        tmr <= '0;
      end else begin
        if (arrive[q]) cnt <= cnt_nx[CNT_W-1:0];
        if (cnt != '0) tmr <= tmr_nx[TMO_W-1:0];
      end
    end

    // R12
    idle_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0) |-> (tmr == '0));
    // R8
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_cnt[q] |=> (cnt == '0));
    // R10
    tmo_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_tmo[q] |=> raw_q[TO_BIT]);
  end

  assign set_vec = (evt_i & ~OWN_MASK)
                 | ({31'd0, hit_cnt[0]} << RX_IN) | ({31'd0, hit_cnt[1]} << TX_IN)
                 | ({31'd0, hit_tmo[0]} << RX_TO) | ({31'd0, hit_tmo[1]} << TX_TO);
  assign clr_vec = (reg_we_i && reg_addr_i == 3'd0) ? reg_wdata_i : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q    <= '0;
      en_q     <= '0;
      thr_q[0] <= CNT_W'(RX_THR_RST);
      thr_q[1] <= CNT_W'(TX_THR_RST);
      tmo_q[0] <= TMO_W'(RX_TMO_RST);
      tmo_q[1] <= TMO_W'(TX_TMO_RST);
      irq_q    <= 1'b0;
    end else begin
      raw_q <= (raw_q & ~clr_vec) | set_vec;
      irq_q <= |(raw_q & en_q);
      if (reg_we_i) begin
        case (reg_addr_i)
          3'd1: en_q <= reg_wdata_i;
          3'd3: begin
            thr_q[0] <= reg_wdata_i[CNT_W-1:0];
            thr_q[1] <= reg_wdata_i[16 +: CNT_W];
          end
          3'd4: tmo_q[0] <= reg_wdata_i[TMO_W-1:0];
          3'd5: tmo_q[1] <= reg_wdata_i[TMO_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr_i)
      3'd0:    reg_rdata_o = raw_q;
      3'd1:    reg_rdata_o = en_q;
      3'd2:    reg_rdata_o = raw_q & en_q;
      3'd3:    reg_rdata_o = (32'(thr_q[1]) << 16) | 32'(thr_q[0]);
      3'd4:    reg_rdata_o = 32'(tmo_q[0]);
      3'd5:    reg_rdata_o = 32'(tmo_q[1]);
      default: reg_rdata_o = 32'd0;
    endcase
  end

  assign irq_o = irq_q;

  // R4
  w1c_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i == 3'd0) |=>
      ((raw_q & $past(reg_wdata_i & set_vec)) == $past(reg_wdata_i & set_vec)));
  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_addr_i == 3'd0) |=> ((raw_q & $past(reg_wdata_i & ~set_vec)) == 32'd0));
  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & en_q) == 32'd0) |=> !irq_o);
  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(raw_q & en_q) != 32'd0));
endmodule

// File: tb/irq_coalesce_tb.sv
`timescale 1ns/1ps
module irq_coalesce_tb;
  localparam logic [31:0] OWN = (32'd1 << 17) | (32'd1 << 19) | (32'd1 << 28) | (32'd1 << 29);

  logic clk = 0, rst_n = 0;
  logic [31:0] evt_i = 0;
  logic rx_arrive_i = 0, tx_arrive_i = 0, reg_we_i = 0;
  logic [2:0] reg_addr_i = 0;
  logic [31:0] reg_wdata_i = 0, reg_rdata_o;
  logic irq_o;
  int n_chk = 0, n_bad = 0;
  logic done = 0;

  irq_coalesce u_dut (.clk, .rst_n, .evt_i, .rx_arrive_i, .tx_arrive_i,
    .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .irq_o);

  always #2.5 clk = ~clk;

  function automatic logic [31:0] next_raw(logic [31:0] raw, logic [31:0] clr, logic [31:0] evt);
    return (raw & ~clr) | (evt & ~OWN);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk); @(negedge clk);
    reg_we_i = 0;
  endtask

  task automatic pulse(int q);
    if (q == 0) rx_arrive_i = 1; else tx_arrive_i = 1;
    @(posedge clk); @(negedge clk);
    rx_arrive_i = 0; tx_arrive_i = 0;
  endtask

  task automatic tmo_case(string req, int q, int t, logic [31:0] bitm);
    logic [31:0] d;
    pulse(q);
    repeat (t - 1) @(posedge clk);
    @(negedge clk); rd(0, d); chk({req, " early"}, d, 32'd0);
    @(posedge clk); @(negedge clk); rd(0, d); chk({req, " due"}, d, bitm);
    chk("R6 irq lag", {31'd0, irq_o}, 32'd0);
    @(posedge clk); @(negedge clk); chk("R6 irq up", {31'd0, irq_o}, 32'd1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, exp_raw, exp_en, nr, ne, clr;
    logic exp_irq, ni;
    int seed_v;
    seed_v = $urandom(32'h5EED1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(0, d); chk("R1 raw", d, 0);
    rd(1, d); chk("R1 en", d, 0);
    rd(2, d); chk("R1 masked", d, 0);
    rd(3, d); chk("R1 thr", d, 32'h00010001);
    rd(4, d); chk("R1 rx tmo", d, 32'h10000);
    rd(5, d); chk("R1 tx tmo", d, 32'h50000);
    chk("R1 irq", {31'd0, irq_o}, 0);
    // R8 default threshold of one
    pulse(0); rd(0, d); chk("R8 default", d, 32'd1 << 17);
    wr(0, 32'hFFFFFFFF); rd(0, d); chk("R3 all ones", d, 0);
    wr(4, 20); wr(5, 30); wr(3, {16'd2, 16'd3});
    // R8
    pulse(0); pulse(0); rd(0, d); chk("R8 below", d, 0);
    pulse(0); rd(0, d); chk("R8 reach", d, 32'd1 << 17);
    wr(0, 32'd1 << 17);
    // R9
    pulse(1); rd(0, d); chk("R9 below", d, 0);
    pulse(1); rd(0, d); chk("R9 reach", d, 32'd1 << 19);
    wr(0, 32'd1 << 19); rd(0, d); chk("R3 single", d, 0);
    // R10
    wr(1, 32'd1 << 28);
    tmo_case("R10", 0, 20, 32'd1 << 28);
    rd(2, d); chk("R5 masked", d, 32'd1 << 28);
    pulse(0); pulse(0); rd(0, d); chk("R10 count dropped", d, 32'd1 << 28);
    pulse(0); rd(0, d); chk("R8 after tmo", d, (32'd1 << 28) | (32'd1 << 17));
    rd(2, d); chk("R5 masked sel", d, 32'd1 << 28);
    wr(0, 32'hFFFFFFFF);
    // R11
    wr(1, 32'd1 << 29);
    tmo_case("R11", 1, 30, 32'd1 << 29);
    wr(0, 32'd1 << 29);
    pulse(1); rd(0, d); chk("R11 count dropped", d, 0);
    pulse(1); rd(0, d); chk("R9 after tmo", d, 32'd1 << 19);
    wr(0, 32'hFFFFFFFF);
    // R12
    repeat (100) @(posedge clk);
    @(negedge clk); rd(0, d); chk("R12 idle", d, 0);
    // R7
    evt_i = OWN; @(posedge clk); @(negedge clk); evt_i = 0;
    rd(0, d); chk("R7 ignored", d, 0);
    // R4
    evt_i = 32'd1 << 5; wr(0, 32'd1 << 5); evt_i = 0;
    rd(0, d); chk("R4 race", d, 32'd1 << 5);
    wr(0, 32'd1 << 5); rd(0, d); chk("R3 clear", d, 0);
    // R2
    evt_i = 32'h4000F00F; @(posedge clk); @(negedge clk); evt_i = 0;
    repeat (3) @(posedge clk); @(negedge clk);
    rd(0, d); chk("R2 held", d, 32'h4000F00F);
    wr(0, 32'h0000000F); rd(0, d); chk("R3 partial", d, 32'h4000F000);
    wr(0, 32'hFFFFFFFF); wr(1, 0);
    exp_raw = 0; exp_en = 0; exp_irq = 0;
    for (int i = 0; i < 400; i++) begin
      rd(0, d); chk("R2 random raw", d, exp_raw);
      rd(2, d); chk("R5 random masked", d, exp_raw & exp_en);
      chk("R6 random irq", {31'd0, irq_o}, {31'd0, exp_irq});
      clr = 0; ne = exp_en;
      evt_i = $urandom & $urandom & $urandom;
      case ($urandom % 4)
        0: begin reg_we_i = 1; reg_addr_i = 0; reg_wdata_i = $urandom; clr = reg_wdata_i; end
        1: begin reg_we_i = 1; reg_addr_i = 1; reg_wdata_i = $urandom; ne = reg_wdata_i; end
        default: reg_we_i = 0;
      endcase
      nr = next_raw(exp_raw, clr, evt_i);
      ni = |(exp_raw & exp_en);
      @(posedge clk); @(negedge clk);
      reg_we_i = 0; evt_i = 0;
      exp_raw = nr; exp_en = ne; exp_irq = ni;
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule